// File: doc/BRIEF.md
# Asynchronous SRAM/NOR Timing Controller

This block turns single-transfer requests from an internal bus (address, write data, direction, byte enables, with a valid/ready handshake) into the chip-select, output-enable, write-enable, address, byte-lane and data-bus signals of one bank of external asynchronous SRAM or NOR memory. Each access runs as an address phase followed by a data phase. A static configuration sets the length of each phase in system clock cycles, and reads and writes share that one timing set.

An optional wait input, with a selectable active level, can stretch the data phase for slow devices. A programmable turnaround gap keeps chip select high between accesses. Software-visible enables gate the whole bank and, separately, write traffic. A write that arrives while writes are disabled is answered with an error and never reaches the memory pins. The external data bus is 16 bits wide, and a narrow mode uses only its low byte.

Top module: `sram_nor_timing_ctrl`

## Requirements
- R1: After reset mem_cs_n, mem_oe_n and mem_we_n are 1, mem_be_n is all ones, mem_dq_oe is 0 and rsp_valid is 0.
- R2: While cfg_bank_en is 0, req_ready stays 0 and chip select is never asserted, even with req_valid held high.
- R3: The address phase (mem_cs_n low, both strobes high) lasts cfg_addr_setup cycles; a value of 0 gives one cycle.
- R4: With no wait request the data phase lasts cfg_data_setup cycles, with 0 treated as 1. mem_oe_n is low for all of a read's data phase, and mem_we_n is low for all of a write's data phase and at no other time.
- R5: For a write, mem_dq_oe is 1 from the first address cycle through the last data cycle and 0 otherwise. mem_dq_o carries the write data over that window. mem_addr holds the request address for the whole access.
- R6: rsp_valid pulses in the first cycle after the data phase, which is also the first cycle with mem_cs_n high again. rsp_err is 0 and, for a read, rsp_rdata holds the mem_dq_i value present in the last data cycle.
- R7: With cfg_wait_en set, mem_wait passes through WAIT_SYNC flops (default 2). The data phase ends on the first clock edge at which its count has run out and the synchronized wait is inactive. If mem_wait is first sampled inactive at edge R after the accepting edge, the data phase lasts max(D, R+WAIT_SYNC−A) cycles, where A and D are the clamped phase lengths. A wait request during the address phase alone stretches nothing.
- R8: With cfg_wait_en clear, mem_wait has no effect on any phase length.
- R9: The wait request level equals cfg_wait_pol (1 = high requests a wait, 0 = low requests a wait). The other level means ready.
- R10: Between two accesses mem_cs_n stays high for at least cfg_turnaround+1 cycles, and for exactly that many when requests are back to back.
- R11: A write accepted while cfg_wr_en is 0 gives rsp_valid with rsp_err = 1 in the cycle after acceptance. Chip select and write enable are never asserted for it.
- R12: Byte lanes: with cfg_wide = 1, mem_be_n = ~req_be (bit 0 = low byte, active low) during the access, and all 16 data bits are used. With cfg_wide = 0, mem_be_n stays 2'b11, only bits 7:0 carry data, the upper byte of mem_dq_o is 0 and the upper byte of rsp_rdata is 0.
- R13: A read never asserts mem_we_n or mem_dq_oe, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bank_en | input | 1 | Bank enable; no access starts while 0 |
| cfg_wr_en | input | 1 | Allows write accesses |
| cfg_wide | input | 1 | 1 = 16-bit memory, 0 = 8-bit memory |
| cfg_wait_en | input | 1 | Enables wait stretching of the data phase |
| cfg_wait_pol | input | 1 | Level of mem_wait that requests a wait |
| cfg_addr_setup | input | 4 | Address phase length in cycles (0 acts as 1) |
| cfg_data_setup | input | 8 | Data phase length in cycles (0 acts as 1) |
| cfg_turnaround | input | 4 | Minimum idle cycles with chip select high, minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a refused write |
| rsp_rdata | output | DW | Read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | DW/8 | Byte lane enables, active low |
| mem_dq_o | output | DW | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data bus sampled value |
| mem_wait | input | 1 | Wait request from the memory |

## Verification
The phase counters are swept across setup values 0, 1, 2, 5 and 15 and data values 0, 1, 3 and 8, for reads and writes in both bus widths. This shows the clamping of zero apart from real counts, and tells an address-length fault from a data-length fault, because each phase is measured on its own. Wait stretching is tried with the release placed at many cycles relative to the access, under both polarities. Early releases must leave the phase at its programmed length and late ones must extend it by exactly the synchronizer delay. The same wait level is also tried as the inactive polarity and with the feature disabled. Back-to-back pairs at every turnaround value from 0 to 15 pin the gap, and refused writes, a disabled bank and address-dependent read patterns separate the error, gating and capture paths.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } smc_phase_e;

    localparam int CNT_W = 8;

    // Phase lengths of zero are stretched to one cycle.
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/smc_wait_sync.sv
module smc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_raw,
    input  logic wait_en,
    input  logic wait_pol,
    output logic wait_req
);

    logic wait_seen;

    generate
        if (STAGES == 0) begin : g_direct
            assign wait_seen = wait_raw;
        end else begin : g_flops
            logic [STAGES-1:0] sync_d, sync_q;

            always_comb begin
                sync_d[0] = wait_raw;
                for (int i = 1; i < STAGES; i++) begin
                    sync_d[i] = sync_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sync_d;
            end

            assign wait_seen = sync_q[STAGES-1];
        end
    endgenerate

    // Request when enabled and the line sits at the selected level.
    assign wait_req = wait_en && (wait_seen == wait_pol);

endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
    import smc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_en,
    input  logic             wr_allow,
    input  logic [3:0]       addr_setup,
    input  logic [7:0]       data_setup,
    input  logic [3:0]       turnaround,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             wait_req,
    output logic             req_ready,
    output logic             accept_ok,
    output logic             reject,
    output logic             data_exit,
    output smc_phase_e       phase_q,
    output smc_phase_e       phase_nxt
);

    typedef struct packed {
        smc_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    assign req_ready = (s_q.phase == PH_IDLE) && bank_en;
    assign accept    = req_valid && req_ready;

    always_comb begin
        s_d       = s_q;
        reject    = accept && req_write && !wr_allow;
        accept_ok = accept && !reject;
        data_exit = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept_ok) begin
                    s_d.phase = PH_ADDR;
                    s_d.cnt   = at_least_one(CNT_W'(addr_setup));
                end
            end
            PH_ADDR: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = at_least_one(data_setup);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_DATA: begin
                if (s_q.cnt != CNT_W'(1)) begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (!wait_req) begin
                    data_exit = 1'b1;
                    if (turnaround != 4'd0) begin
                        s_d.phase = PH_GAP;
                        s_d.cnt   = CNT_W'(turnaround);
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end
            end
            PH_GAP: begin
                if (s_q.cnt == CNT_W'(1)) s_d.phase = PH_IDLE;
                else                      s_d.cnt   = s_q.cnt - CNT_W'(1);
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q   = s_q.phase;
    assign phase_nxt = s_d.phase;

    // Checker: cycles spent so far in the current data phase.
    logic [CNT_W-1:0] dcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 dcnt_q <= '0;
        else if (s_q.phase == PH_DATA && !data_exit) dcnt_q <= (dcnt_q == '1) ? dcnt_q : dcnt_q + CNT_W'(1);
        else                                        dcnt_q <= '0;
    end

    p_data_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_exit |-> ({1'b0, dcnt_q} + 9'd1 >= {1'b0, at_least_one(data_setup)}));

    p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DATA && s_q.cnt == CNT_W'(1) && wait_req) |=> (s_q.phase == PH_DATA));

    p_start_needs_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ADDR && $past(s_q.phase) == PH_IDLE) |-> $past(bank_en));

    p_refused_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (s_q.phase == PH_IDLE));

endmodule

// File: rtl/smc_bus_path.sv
module smc_bus_path
    import smc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic [3:0]      turnaround,
    input  logic            accept_ok,
    input  logic            reject,
    input  logic            data_exit,
    input  smc_phase_e      phase_nxt,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    input  logic [DW-1:0]   mem_dq_i,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_cs_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be_n,
    output logic [DW-1:0]   mem_dq_o,
    output logic            mem_dq_oe
);

    localparam int LANES = DW / 8;
    localparam logic [DW-1:0] LOW_BYTE = DW'(8'hFF);

    typedef struct packed {
        logic             write;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dq_o;
        logic [LANES-1:0] be;
        logic             cs_n;
        logic             oe_n;
        logic             we_n;
        logic             dq_oe;
        logic [LANES-1:0] be_n;
        logic             rsp_valid;
        logic             rsp_err;
        logic [DW-1:0]    rdata;
    } bus_t;

    bus_t b_d, b_q;
    logic active_nxt;
    logic wr_nxt;

    always_comb begin
        b_d = b_q;
        if (accept_ok) begin
            b_d.write = req_write;
            b_d.addr  = req_addr;
            b_d.dq_o  = wide ? req_wdata : (req_wdata & LOW_BYTE);
            b_d.be    = req_be;
        end
        wr_nxt     = accept_ok ? req_write : b_q.write;
        active_nxt = (phase_nxt == PH_ADDR) || (phase_nxt == PH_DATA);

        b_d.cs_n  = !active_nxt;
        b_d.oe_n  = !((phase_nxt == PH_DATA) && !wr_nxt);
        b_d.we_n  = !((phase_nxt == PH_DATA) && wr_nxt);
        b_d.dq_oe = active_nxt && wr_nxt;
        b_d.be_n  = (active_nxt && wide) ? ~b_d.be : '1;

        b_d.rsp_valid = data_exit || reject;
        b_d.rsp_err   = reject;
        if (data_exit && !b_q.write) begin
            b_d.rdata = wide ? mem_dq_i : (mem_dq_i & LOW_BYTE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.write     <= 1'b0;
            b_q.addr      <= '0;
            b_q.dq_o      <= '0;
            b_q.be        <= '0;
            b_q.cs_n      <= 1'b1;
            b_q.oe_n      <= 1'b1;
            b_q.we_n      <= 1'b1;
            b_q.dq_oe     <= 1'b0;
            b_q.be_n      <= '1;
            b_q.rsp_valid <= 1'b0;
            b_q.rsp_err   <= 1'b0;
            b_q.rdata     <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rsp_valid = b_q.rsp_valid;
    assign rsp_err   = b_q.rsp_err;
    assign rsp_rdata = b_q.rdata;
    assign mem_cs_n  = b_q.cs_n;
    assign mem_oe_n  = b_q.oe_n;
    assign mem_we_n  = b_q.we_n;
    assign mem_addr  = b_q.addr;
    assign mem_be_n  = b_q.be_n;
    assign mem_dq_o  = b_q.dq_o;
    assign mem_dq_oe = b_q.dq_oe;

    // Checker: consecutive cycles with chip select high.
    logic [4:0] hi_cnt_q;
    logic       seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
            seen_q   <= 1'b0;
        end else begin
            hi_cnt_q <= !mem_cs_n ? 5'd0 : (hi_cnt_q == 5'd31 ? hi_cnt_q : hi_cnt_q + 5'd1);
            if (!mem_cs_n) seen_q <= 1'b1;
        end
    end

    p_gap_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && seen_q) |-> (hi_cnt_q >= {1'b0, turnaround} + 5'd1));

    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_we_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    p_drive_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs_n && mem_oe_n));

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    p_err_no_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (mem_cs_n && $past(mem_cs_n) && mem_we_n));

    p_rsp_after_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (mem_cs_n && !$past(mem_cs_n)));

endmodule

// File: rtl/sram_nor_timing_ctrl.sv
module sram_nor_timing_ctrl
    import smc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int WAIT_SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_bank_en,
    input  logic            cfg_wr_en,
    input  logic            cfg_wide,
    input  logic            cfg_wait_en,
    input  logic            cfg_wait_pol,
    input  logic [3:0]      cfg_addr_setup,
    input  logic [7:0]      cfg_data_setup,
    input  logic [3:0]      cfg_turnaround,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic            mem_cs_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be_n,
    output logic [DW-1:0]   mem_dq_o,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_i,
    input  logic            mem_wait
);

    logic       wait_req;
    logic       accept_ok;
    logic       reject;
    logic       data_exit;
    smc_phase_e phase_q;
    smc_phase_e phase_nxt;

    smc_wait_sync #(.STAGES(WAIT_SYNC)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_raw (mem_wait),
        .wait_en  (cfg_wait_en),
        .wait_pol (cfg_wait_pol),
        .wait_req (wait_req)
    );

    smc_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_en    (cfg_bank_en),
        .wr_allow   (cfg_wr_en),
        .addr_setup (cfg_addr_setup),
        .data_setup (cfg_data_setup),
        .turnaround (cfg_turnaround),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .wait_req   (wait_req),
        .req_ready  (req_ready),
        .accept_ok  (accept_ok),
        .reject     (reject),
        .data_exit  (data_exit),
        .phase_q    (phase_q),
        .phase_nxt  (phase_nxt)
    );

    smc_bus_path #(.AW(AW), .DW(DW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (cfg_wide),
        .turnaround (cfg_turnaround),
        .accept_ok  (accept_ok),
        .reject     (reject),
        .data_exit  (data_exit),
        .phase_nxt  (phase_nxt),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_be     (req_be),
        .mem_dq_i   (mem_dq_i),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_be_n   (mem_be_n),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe)
    );

    // Pins only leave the idle level while a phase is in progress.
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE || phase_q == PH_GAP) |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/sram_nor_timing_ctrl_tb.sv
`timescale 1ns/1ps
module sram_nor_timing_ctrl_tb_top;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cfg_bank_en = 1'b1, cfg_wr_en = 1'b1, cfg_wide = 1'b1;
    logic        cfg_wait_en = 1'b0, cfg_wait_pol = 1'b1;
    logic [3:0]  cfg_addr_setup = 4'd1, cfg_turnaround = 4'd0;
    logic [7:0]  cfg_data_setup = 8'd1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        mem_wait = 1'b0;
    logic        req_ready, rsp_valid, rsp_err, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
    logic [1:0]  mem_be_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    function automatic logic [15:0] pat(input logic [15:0] a);
        return (a * 16'd3) ^ 16'hA5C3;
    endfunction

    assign mem_dq_i = pat(mem_addr);

    sram_nor_timing_ctrl #(.AW(AW), .DW(DW), .WAIT_SYNC(WS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en), .cfg_wide(cfg_wide),
        .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .cfg_addr_setup(cfg_addr_setup), .cfg_data_setup(cfg_data_setup),
        .cfg_turnaround(cfg_turnaround),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One access; rel_n > 0 releases an active wait at that negedge after acceptance.
    task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                              input logic [1:0] be, input bit wait_on, input int rel_n, input string tag);
        int alen, dlen, exp_a, exp_d, n;
        bit bad_strobe, bad_oe, bad_addr, bad_be, bad_dq, split;
        logic [1:0]  exp_be_n;
        logic [15:0] exp_dq, exp_rd;
        exp_a = (cfg_addr_setup == 0) ? 1 : int'(cfg_addr_setup);
        exp_d = (cfg_data_setup == 0) ? 1 : int'(cfg_data_setup);
        if (cfg_wait_en && wait_on && (rel_n + WS - exp_a > exp_d)) exp_d = rel_n + WS - exp_a;
        exp_be_n = cfg_wide ? ~be : 2'b11;
        exp_dq   = cfg_wide ? wd : {8'h00, wd[7:0]};
        exp_rd   = cfg_wide ? pat(a) : {8'h00, pat(a)[7:0]};
        alen = 0; dlen = 0;
        bad_strobe = 0; bad_oe = 0; bad_addr = 0; bad_be = 0; bad_dq = 0; split = 0;
        @(negedge clk);
        mem_wait  = wait_on ? cfg_wait_pol : ~cfg_wait_pol;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 2000) begin
            if (n == rel_n) mem_wait = ~cfg_wait_pol;
            if (!mem_cs_n) begin
                if (dlen > 0 && mem_oe_n && mem_we_n) split = 1;
                if (mem_oe_n && mem_we_n) alen++; else dlen++;
                if (wr ? !mem_oe_n : !mem_we_n) bad_strobe = 1;
                if (mem_dq_oe !== wr) bad_oe = 1;
                if (mem_addr !== a) bad_addr = 1;
                if (mem_be_n !== exp_be_n) bad_be = 1;
                if (wr && mem_dq_o !== exp_dq) bad_dq = 1;
            end else if (alen > 0) split = 1;
            @(negedge clk);
            n++;
        end
        mem_wait = ~cfg_wait_pol;
        chk(alen == exp_a && !split, "R3", {tag, " address phase cycles"}, alen, exp_a);
        chk(dlen == exp_d, wait_on ? "R7" : "R4", {tag, " data phase cycles"}, dlen, exp_d);
        chk(!bad_strobe, wr ? "R4" : "R13", {tag, " wrong strobe"}, int'(bad_strobe), 0);
        chk(!bad_oe && !bad_addr && !bad_dq, "R5", {tag, " drive/addr/data"},
            int'({bad_oe, bad_addr, bad_dq}), 0);
        chk(!bad_be, "R12", {tag, " byte lanes"}, int'(bad_be), 0);
        chk(rsp_valid && !rsp_err && mem_cs_n, "R6", {tag, " response"}, int'({rsp_valid, rsp_err, mem_cs_n}), 5);
        if (!wr) chk(rsp_rdata === exp_rd, "R6", {tag, " read data"}, int'(rsp_rdata), int'(exp_rd));
        if (!wr && !cfg_wide) chk(rsp_rdata[15:8] === 8'h00, "R12", {tag, " narrow upper byte"},
                                  int'(rsp_rdata[15:8]), 0);
        @(negedge clk);
        chk(!rsp_valid, "R6", {tag, " response is one pulse"}, int'(rsp_valid), 0);
    endtask

    task automatic gap_pair(input int ta);
        int highs, st, n;
        cfg_turnaround = 4'(ta);
        highs = 0; st = 0; n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0040 + 16'(ta);
        while (st < 3 && n < 500) begin
            @(negedge clk);
            n++;
            case (st)
                0: if (!mem_cs_n) st = 1;
                1: if (mem_cs_n) begin st = 2; highs = 1; end
                2: if (mem_cs_n) highs++; else begin st = 3; req_valid = 1'b0; end
                default: ;
            endcase
        end
        chk(highs == ta + 1, "R10", $sformatf("turnaround %0d idle cycles", ta), highs, ta + 1);
        while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
        repeat (ta + 2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] asv [5];
        logic [7:0] dsv [4];
        asv = '{4'd0, 4'd1, 4'd2, 4'd5, 4'd15};
        dsv = '{8'd0, 8'd1, 8'd3, 8'd8};
        repeat (4) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && mem_be_n == 2'b11,
            "R1", "pins during reset", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}), 28);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready,
            "R1", "idle after reset", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready}), 57);

        // R2: bank disabled
        cfg_bank_en = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0011;
        begin
            bit seen_bad = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (req_ready || !mem_cs_n) seen_bad = 1;
            end
            chk(!seen_bad, "R2", "bank disabled blocks access", int'(seen_bad), 0);
        end
        req_valid = 1'b0;
        cfg_bank_en = 1'b1;

        // Timing sweep, both widths, read and write
        for (int w = 0; w < 2; w++) begin
            cfg_wide = w[0];
            foreach (asv[i]) begin
                foreach (dsv[j]) begin
                    cfg_addr_setup = asv[i];
                    cfg_data_setup = dsv[j];
                    run_access(1'b0, 16'(100 + i * 7 + j), 16'h0, 2'b11, 1'b0, 0,
                               $sformatf("rd w%0d a%0d d%0d", w, asv[i], dsv[j]));
                    run_access(1'b1, 16'(300 + i * 5 + j), 16'(16'hC35A ^ 16'(i * 31 + j)),
                               2'(i + j + 1), 1'b0, 0,
                               $sformatf("wr w%0d a%0d d%0d", w, asv[i], dsv[j]));
                end
            end
        end

        // R7/R9: wait stretching, release point swept, both polarities
        cfg_wide = 1'b1; cfg_addr_setup = 4'd2; cfg_data_setup = 8'd3;
        cfg_wait_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cfg_wait_pol = p[0];
            for (int r = 1; r <= 9; r++) begin
                run_access(r[0], 16'(500 + r), 16'(16'h1234 + r), 2'b11, 1'b1, r,
                           $sformatf("wait pol%0d rel%0d", p, r));
            end
            // R9: line held at the opposite level is ready
            @(negedge clk);
            run_access(1'b0, 16'h0600, 16'h0, 2'b11, 1'b0, 0, $sformatf("R9 ready level pol%0d", p));
        end
        // R8: wait disabled, line held at the request level
        cfg_wait_en = 1'b0;
        cfg_wait_pol = 1'b1;
        run_access(1'b0, 16'h0700, 16'h0, 2'b11, 1'b1, 30, "R8 wait disabled");

        // R10: back-to-back turnaround
        cfg_addr_setup = 4'd0; cfg_data_setup = 8'd0;
        for (int t = 0; t < 16; t++) gap_pair(t);
        cfg_turnaround = 4'd0;

        // R11: refused write
        cfg_wr_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0BAD; req_wdata = 16'hFFFF;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_err, "R11", "refused write error response",
            int'({rsp_valid, rsp_err}), 3);
        chk(mem_cs_n && mem_we_n && !mem_dq_oe, "R11", "refused write stays off pins",
            int'({mem_cs_n, mem_we_n, mem_dq_oe}), 6);
        begin
            bit touched = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!mem_cs_n || !mem_we_n || rsp_valid) touched = 1;
            end
            chk(!touched, "R11", "nothing after refused write", int'(touched), 0);
        end
        cfg_wr_en = 1'b1;
        run_access(1'b1, 16'h0ACE, 16'h5AA5, 2'b01, 1'b0, 0, "R11 write allowed again");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule